// File: doc/BRIEF.md
# Multiplexed Parallel Bus Master

This block drives an external parallel bus on behalf of an on-chip requester. A single request carries a 16-bit address, up to 16 bits of write data, a direction bit, a data-width bit and two chip-select enables. The block then runs a complete bus cycle on the pins: an optional address phase with latch strobes, then a read or write strobe of fixed width. Read data comes back together with a one-cycle acknowledge.

A 2-bit mode input selects how the address reaches the external device. It can sit on its own address pins. The low byte can share the data pins. All 16 bits can share the low data byte in two steps, or all 16 data pins in one step. The latch strobes for the low and high address parts leave on address pins 0 and 1. Address pins 14 and 15 can instead carry two active-high chip selects. Every output is a register, and the pins drive a fixed, known pattern in every cycle.

Top module: `muxbus_master`

## Requirements
- R1: While reset is held and after it is released, every pin output, every output-enable bit, `busy`, `ack`, `pin_rd`, `pin_wr` and `rd_data` are zero.
- R2: Mode 2'b00 (separate buses) has no address phase. For the whole transfer, `pin_addr[13:0]` carries address bits 13:0, and the data pins carry only transfer data.
- R3: Mode 2'b01 (low byte shared) has two address-phase cycles. In the first, `pin_addr[0]` is high. In both, `pin_data_o[7:0]` holds address bits 7:0 with `pin_data_oe` = 2'b01. For the whole transfer, `pin_addr[15:8]` carries address bits 15:8, and `pin_addr[7:1]` stays zero.
- R4: Mode 2'b10 (full address over 8 pins) has four address-phase cycles: low byte with `pin_addr[0]` high, low byte held, high byte with `pin_addr[1]` high, high byte held. `pin_data_oe` is 2'b01 throughout.
- R5: Mode 2'b11 (full address over 16 pins) has two address-phase cycles. The whole address sits on `pin_data_o` with `pin_data_oe` = 2'b11, and `pin_addr[0]` and `pin_addr[1]` are both high in the first cycle only.
- R6: When `req_cs1_en` (or `req_cs2_en`) is set, `pin_addr[14]` (or `pin_addr[15]`) is high in every cycle of the transfer, from the first address-phase cycle to the last strobe cycle. When the enable is clear, that pin carries its address bit in modes 00 and 01 and stays zero in modes 10 and 11.
- R7: In modes 10 and 11, address bit 14 (or 15) is put out as zero on the data pins when chip select 1 (or 2) is enabled.
- R8: A write drives the write data with `pin_wr` high for STROBE_CLKS cycles. `pin_data_oe[0]` covers bits 7:0, and `pin_data_oe[1]` and bits 15:8 are driven only when `req_wide` is set.
- R9: A read holds `pin_data_oe` at zero with `pin_rd` high for STROBE_CLKS cycles. `rd_data` takes the value on `pin_data_i` during the last strobe cycle, with the upper byte zeroed when `req_wide` is clear.
- R10: `busy` is high from the cycle after a request is taken until the transfer ends. `ack` is high for exactly one cycle right after the last strobe cycle. A request, a field change or a mode change while `busy` is high has no effect on the transfer.
- R11: Outside a transfer, and on pins the current mode and phase do not use, outputs are zero and their output-enable bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Address multiplexing mode, sampled when a request is taken |
| req | input | 1 | Transfer request, taken when `busy` is low |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| req_cs1_en | input | 1 | Use address pin 14 as chip select 1 |
| req_cs2_en | input | 1 | Use address pin 15 as chip select 2 |
| busy | output | 1 | Transfer in progress |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `ack` |
| pin_addr | output | 16 | Address / strobe / chip-select pins |
| pin_data_o | output | 16 | Data pins, outgoing value |
| pin_data_oe | output | 2 | Output enable per data byte lane |
| pin_data_i | input | 16 | Data pins, incoming value |
| pin_rd | output | 1 | Read strobe |
| pin_wr | output | 1 | Write strobe |

## Verification
Two things meet in the same cycle here. A chip select on address pin 14 or 15 can fall in the same cycle as a latch strobe, while the forced-zero address bit is on the data pins. And a new request can arrive in the middle of a transfer, together with a change of the mode input. The bench pairs both enables with all-ones addresses in the full multiplexed modes. In random transfers it raises a request with scrambled fields and a scrambled mode in the first busy cycle. Every pin is compared against a cycle-indexed expectation built from the mode and request alone, and a transfer passes only if that stray request and mode change leave no trace.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    MD_SPLIT   = 2'b00,
    MD_LOWMUX  = 2'b01,
    MD_FULL8   = 2'b10,
    MD_FULL16  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LL      = 3'd1,
    PH_LL_HOLD = 3'd2,
    PH_LH      = 3'd3,
    PH_LH_HOLD = 3'd4,
    PH_STRB    = 3'd5
  } phase_e;

  typedef struct packed {
    mode_e              mode;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  wdata;
    logic               write;
    logic               wide;
    logic               cs1;
    logic               cs2;
  } xfer_t;

endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
  import mbm_pkg::*;
#(
  parameter int STROBE_CLKS = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  xfer_t  xfer_in,
  output phase_e phase_d,
  output xfer_t  xfer_d,
  output logic   last_strb,
  output logic   busy,
  output logic   cur_write,
  output logic   cur_wide
);

  localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

  phase_e            phase_q;
  xfer_t             xfer_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign last_strb = (phase_q == PH_STRB) && (cnt_q == CNT_LAST);
  assign busy      = (phase_q != PH_IDLE);
  assign cur_write = xfer_q.write;
  assign cur_wide  = xfer_q.wide;

  always_comb begin
    phase_d = phase_q;
    xfer_d  = xfer_q;
    cnt_d   = '0;
    case (phase_q)
      PH_IDLE: begin
        if (req) begin
          xfer_d  = xfer_in;
          phase_d = (xfer_in.mode == MD_SPLIT) ? PH_STRB : PH_LL;
        end
      end
      PH_LL:      phase_d = PH_LL_HOLD;
      PH_LL_HOLD: phase_d = (xfer_q.mode == MD_FULL8) ? PH_LH : PH_STRB;
      PH_LH:      phase_d = PH_LH_HOLD;
      PH_LH_HOLD: phase_d = PH_STRB;
      PH_STRB: begin
        if (cnt_q == CNT_LAST) phase_d = PH_IDLE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      xfer_q  <= '0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      xfer_q  <= xfer_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/mbm_pins.sv
module mbm_pins
  import mbm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  phase_e             phase_d,
  input  xfer_t              xfer_d,
  output logic [ADDR_W-1:0]  pin_addr,
  output logic [DATA_W-1:0]  pin_data_o,
  output logic [LANES-1:0]   pin_data_oe,
  output logic               pin_rd,
  output logic               pin_wr
);

  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;
  logic [LANES-1:0]  oe_n;
  logic              rd_n, wr_n;
  logic              full_mode, in_ll, in_lh, active;

  assign full_mode = (xfer_d.mode == MD_FULL8) || (xfer_d.mode == MD_FULL16);
  assign in_ll     = (phase_d == PH_LL);
  assign in_lh     = (phase_d == PH_LH);
  assign active    = (phase_d != PH_IDLE);

  // Address as it travels over the data pins in the full modes.
  always_comb begin
    eff_addr = xfer_d.addr;
    if (full_mode && xfer_d.cs1) eff_addr[14] = 1'b0;
    if (full_mode && xfer_d.cs2) eff_addr[15] = 1'b0;
  end

  always_comb begin
    addr_n = '0;
    data_n = '0;
    oe_n   = '0;
    rd_n   = 1'b0;
    wr_n   = 1'b0;
    if (active) begin
      case (xfer_d.mode)
        MD_SPLIT:  addr_n = xfer_d.addr;
        MD_LOWMUX: begin
          addr_n[15:8] = xfer_d.addr[15:8];
          addr_n[0]    = in_ll;
        end
        MD_FULL8: begin
          addr_n[0] = in_ll;
          addr_n[1] = in_lh;
        end
        default: begin
          addr_n[0] = in_ll;
          addr_n[1] = in_ll;
        end
      endcase
      if (!full_mode) begin
        addr_n[14] = xfer_d.cs1 ? 1'b1 : xfer_d.addr[14];
        addr_n[15] = xfer_d.cs2 ? 1'b1 : xfer_d.addr[15];
      end else begin
        addr_n[14] = xfer_d.cs1;
        addr_n[15] = xfer_d.cs2;
      end

      case (phase_d)
        PH_LL, PH_LL_HOLD: begin
          if (xfer_d.mode == MD_FULL16) begin
            data_n = eff_addr;
            oe_n   = '1;
          end else begin
            data_n[7:0] = eff_addr[7:0];
            oe_n[0]     = 1'b1;
          end
        end
        PH_LH, PH_LH_HOLD: begin
          data_n[7:0] = eff_addr[15:8];
          oe_n[0]     = 1'b1;
        end
        PH_STRB: begin
          rd_n = !xfer_d.write;
          wr_n = xfer_d.write;
          if (xfer_d.write) begin
            data_n[7:0] = xfer_d.wdata[7:0];
            oe_n[0]     = 1'b1;
            if (xfer_d.wide) begin
              data_n[15:8] = xfer_d.wdata[15:8];
              oe_n[1]      = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_addr <= '0;
      pin_rd   <= 1'b0;
      pin_wr   <= 1'b0;
    end else begin
      pin_addr <= addr_n;
      pin_rd   <= rd_n;
      pin_wr   <= wr_n;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_oe_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q    <= '0;
        lane_oe_q <= 1'b0;
      end else begin
        lane_q    <= data_n[l*8 +: 8];
        lane_oe_q <= oe_n[l];
      end
    end
    assign pin_data_o[l*8 +: 8] = lane_q;
    assign pin_data_oe[l]       = lane_oe_q;
  end

endmodule

// File: rtl/mbm_rdcap.sv
module mbm_rdcap
  import mbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              last_strb,
  input  logic              cur_write,
  input  logic              cur_wide,
  input  logic [DATA_W-1:0] pin_data_i,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= 1'b0;
      rd_data <= '0;
    end else begin
      ack <= last_strb;
      if (last_strb && !cur_write)
        rd_data <= cur_wide ? pin_data_i : {8'h00, pin_data_i[7:0]};
    end
  end

endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
  import mbm_pkg::*;
#(
  parameter int STROBE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic              req_cs1_en,
  input  logic              req_cs2_en,
  output logic              busy,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] pin_addr,
  output logic [DATA_W-1:0] pin_data_o,
  output logic [LANES-1:0]  pin_data_oe,
  input  logic [DATA_W-1:0] pin_data_i,
  output logic              pin_rd,
  output logic              pin_wr
);

  xfer_t  xfer_in, xfer_d;
  phase_e phase_d;
  logic   last_strb, cur_write, cur_wide;

  always_comb begin
    xfer_in.mode  = mode_e'(mode);
    xfer_in.addr  = req_addr;
    xfer_in.wdata = req_wdata;
    xfer_in.write = req_write;
    xfer_in.wide  = req_wide;
    xfer_in.cs1   = req_cs1_en;
    xfer_in.cs2   = req_cs2_en;
  end

  mbm_seq #(.STROBE_CLKS(STROBE_CLKS)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .xfer_in   (xfer_in),
    .phase_d   (phase_d),
    .xfer_d    (xfer_d),
    .last_strb (last_strb),
    .busy      (busy),
    .cur_write (cur_write),
    .cur_wide  (cur_wide)
  );

  mbm_pins pins_i (
    .clk         (clk),
    .rst         (rst),
    .phase_d     (phase_d),
    .xfer_d      (xfer_d),
    .pin_addr    (pin_addr),
    .pin_data_o  (pin_data_o),
    .pin_data_oe (pin_data_oe),
    .pin_rd      (pin_rd),
    .pin_wr      (pin_wr)
  );

  mbm_rdcap rdcap_i (
    .clk        (clk),
    .rst        (rst),
    .last_strb  (last_strb),
    .cur_write  (cur_write),
    .cur_wide   (cur_wide),
    .pin_data_i (pin_data_i),
    .ack        (ack),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/mbm_checker.sv
module mbm_checker (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        ack,
  input logic        pin_rd,
  input logic        pin_wr,
  input logic [1:0]  pin_data_oe
);

  // R8 / R9: never both strobes
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pin_rd && pin_wr));

  // R9: bus released while reading
  a_r9_read_releases_bus: assert property (@(posedge clk) disable iff (rst)
    pin_rd |-> (pin_data_oe == 2'b00));

  // R10: strobes only inside a busy period
  a_r10_strobe_while_busy: assert property (@(posedge clk) disable iff (rst)
    (pin_rd || pin_wr) |-> busy);

  // R10: acknowledge is a single cycle pulse
  a_r10_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R10: acknowledge ends a busy period
  a_r10_ack_after_busy: assert property (@(posedge clk) disable iff (rst)
    ack |-> (!busy && $past(busy)));

  // R11: quiet pins outside a transfer
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pin_data_oe == 2'b00 && !pin_rd && !pin_wr));

endmodule

bind muxbus_master mbm_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .ack         (ack),
  .pin_rd      (pin_rd),
  .pin_wr      (pin_wr),
  .pin_data_oe (pin_data_oe)
);

// File: tb/muxbus_master_tb.sv
`timescale 1ns/1ps
module muxbus_master_tb_top;

  localparam int STB = 3;

  typedef struct {
    logic [1:0]  mode;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic        write;
    logic        wide;
    logic        cs1;
    logic        cs2;
  } tx_s;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = '0;
  logic        req = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, pin_data_i = '0;
  logic        req_write = 1'b0, req_wide = 1'b0, req_cs1_en = 1'b0, req_cs2_en = 1'b0;
  logic        busy, ack, pin_rd, pin_wr;
  logic [15:0] rd_data, pin_addr, pin_data_o;
  logic [1:0]  pin_data_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  muxbus_master #(.STROBE_CLKS(STB)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .req(req), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_wide(req_wide),
    .req_cs1_en(req_cs1_en), .req_cs2_en(req_cs2_en), .busy(busy), .ack(ack),
    .rd_data(rd_data), .pin_addr(pin_addr), .pin_data_o(pin_data_o),
    .pin_data_oe(pin_data_oe), .pin_data_i(pin_data_i), .pin_rd(pin_rd),
    .pin_wr(pin_wr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int addr_cycles(input logic [1:0] m);
    case (m)
      2'b00:   return 0;
      2'b10:   return 4;
      default: return 2;
    endcase
  endfunction

  // Expected pin state in cycle k (1-based) of a transfer
  function automatic void expect_at(input tx_s x, input int k,
      output logic [15:0] pa, output logic [15:0] pd, output logic [1:0] oe,
      output logic rd, output logic wr);
    int na = addr_cycles(x.mode);
    logic full = x.mode[1];
    logic [15:0] ea = x.addr;
    logic ll, lh;
    if (full && x.cs1) ea[14] = 1'b0;
    if (full && x.cs2) ea[15] = 1'b0;
    ll = (k == 1) && (na > 0);
    lh = ((x.mode == 2'b10) && (k == 3)) || ((x.mode == 2'b11) && (k == 1));
    pa = '0; pd = '0; oe = '0; rd = 1'b0; wr = 1'b0;
    case (x.mode)
      2'b00: pa = x.addr;
      2'b01: pa = {x.addr[15:8], 7'b0, ll};
      default: pa = {14'b0, lh, ll};
    endcase
    if (!full) begin
      if (x.cs1) pa[14] = 1'b1;
      if (x.cs2) pa[15] = 1'b1;
    end else begin
      pa[14] = x.cs1;
      pa[15] = x.cs2;
    end
    if (k <= na) begin
      case (x.mode)
        2'b01: begin pd = {8'h00, x.addr[7:0]}; oe = 2'b01; end
        2'b10: begin pd = {8'h00, (k <= 2) ? ea[7:0] : ea[15:8]}; oe = 2'b01; end
        default: begin pd = ea; oe = 2'b11; end
      endcase
    end else if (x.write) begin
      wr = 1'b1;
      pd = x.wide ? x.wdata : {8'h00, x.wdata[7:0]};
      oe = x.wide ? 2'b11 : 2'b01;
    end else begin
      rd = 1'b1;
    end
  endfunction

  task automatic run_xfer(input tx_s x, input bit poke);
    int n = addr_cycles(x.mode) + STB;
    logic [15:0] pa, pd, last_in, v;
    logic [1:0]  oe;
    logic        rd, wr;
    string       dtag;
    mode = x.mode; req_addr = x.addr; req_wdata = x.wdata; req_write = x.write;
    req_wide = x.wide; req_cs1_en = x.cs1; req_cs2_en = x.cs2; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    last_in = '0;
    for (int k = 1; k <= n; k++) begin
      expect_at(x, k, pa, pd, oe, rd, wr);
      chk(mode_tag(x.mode), "addr pins 13:0", {18'b0, pin_addr[13:0]}, {18'b0, pa[13:0]});
      chk("R6", "addr pins 15:14", {30'b0, pin_addr[15:14]}, {30'b0, pa[15:14]});
      if (k <= addr_cycles(x.mode))
        dtag = (x.mode[1] && (x.cs1 || x.cs2)) ? "R7" : mode_tag(x.mode);
      else
        dtag = x.write ? "R8" : "R9";
      chk(dtag, "data out", {16'b0, pin_data_o}, {16'b0, pd});
      chk(dtag, "data oe", {30'b0, pin_data_oe}, {30'b0, oe});
      chk(dtag, "rd/wr", {30'b0, pin_rd, pin_wr}, {30'b0, rd, wr});
      chk("R10", "busy in transfer", {31'b0, busy}, 32'd1);
      if (poke && k == 1) begin
        req = 1'b1; req_addr = ~x.addr; req_wdata = ~x.wdata;
        req_write = ~x.write; req_cs1_en = ~x.cs1; mode = 2'($urandom);
      end else begin
        req = 1'b0;
      end
      v = 16'($urandom);
      pin_data_i = v;
      if (k == n) last_in = v;
      @(negedge clk);
    end
    req = 1'b0;
    chk("R10", "ack at end", {31'b0, ack}, 32'd1);
    chk("R10", "busy at end", {31'b0, busy}, 32'd0);
    if (!x.write)
      chk("R9", "read data", {16'b0, rd_data},
          {16'b0, x.wide ? last_in : {8'h00, last_in[7:0]}});
    chk("R11", "idle pins", {pin_addr, pin_data_o}, 32'd0);
    chk("R11", "idle strobes/oe", {28'b0, pin_data_oe, pin_rd, pin_wr}, 32'd0);
    pin_data_i = 16'($urandom);
    @(negedge clk);
    chk("R10", "ack single pulse", {31'b0, ack}, 32'd0);
  endtask

  function automatic tx_s mk(input logic [1:0] m, input logic [15:0] a,
      input logic [15:0] d, input logic w, input logic wd,
      input logic c1, input logic c2);
    tx_s t;
    t.mode = m; t.addr = a; t.wdata = d; t.write = w; t.wide = wd;
    t.cs1 = c1; t.cs2 = c2;
    return t;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "pins in reset", {pin_addr, pin_data_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pins after reset", {pin_addr, pin_data_o}, 32'd0);
    chk("R1", "ctrl after reset", {11'b0, busy, ack, pin_rd, pin_wr, pin_data_oe, rd_data}, 32'd0);

    // Directed: every mode, reads and writes, both widths
    for (int m = 0; m < 4; m++) begin
      run_xfer(mk(2'(m), 16'hA5C3, 16'h1E2D, 1'b1, 1'b0, 1'b0, 1'b0), 1'b0);
      run_xfer(mk(2'(m), 16'h3C5A, 16'hBEEF, 1'b1, 1'b1, 1'b0, 1'b0), 1'b0);
      run_xfer(mk(2'(m), 16'h0F0F, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0), 1'b0);
      run_xfer(mk(2'(m), 16'hF0F0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0), 1'b0);
    end
    // R6 / R7: chip selects with all-ones addresses, one or both
    for (int m = 0; m < 4; m++) begin
      run_xfer(mk(2'(m), 16'hFFFF, 16'h8001, 1'b1, 1'b1, 1'b1, 1'b1), 1'b0);
      run_xfer(mk(2'(m), 16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0), 1'b0);
      run_xfer(mk(2'(m), 16'h0000, 16'h7FFE, 1'b1, 1'b0, 1'b0, 1'b1), 1'b0);
    end
    // R10: stray request and mode change during a transfer, back to back
    run_xfer(mk(2'b10, 16'h1234, 16'h5678, 1'b1, 1'b0, 1'b0, 1'b0), 1'b1);
    run_xfer(mk(2'b00, 16'h4321, 16'h8765, 1'b0, 1'b1, 1'b1, 1'b0), 1'b1);

    // Constrained random
    for (int i = 0; i < 60; i++) begin
      run_xfer(mk(2'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom)), 1'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule